// File: doc/BRIEF.md
# I2C Slave Write Receiver with Software-Held Acknowledge

This block receives master-write transfers as a 7-bit-address I2C slave. It watches the open-drain clock and data lines through input pins and pulls them low through output-enable pins. It detects Start and Stop conditions, shifts in address and data bytes MSB first, compares the address against a programmable own address, and acknowledges bytes. It can stretch the clock so that slow software can keep pace with the bus.

Software sees a small set of flag and strobe pins. These cover a receive buffer with full and overflow flags, Start and Stop status, the captured R/W bit, and a sticky interrupt flag. A clock-release bit lets software free a stretched clock. Two optional hold modes stop the bus after the eighth bit of an address or data byte. In these modes software inspects the byte and chooses the acknowledge value before the ninth clock. A timing flag tells whether a pending interrupt came before or after the acknowledge.

Top module: `i2c_hold_rx`

## Requirements
- R1: After reset the buffer-full, overflow, interrupt, Start, Stop, R/W and ack-timing flags are 0, the clock-release bit is 1, and neither line is pulled low.
- R2: SDA falling while SCL is high sets the Start flag and clears the Stop flag. The interrupt flag is set by it only when the start-interrupt enable is 1.
- R3: SDA rising while SCL is high sets the Stop flag and clears the Start flag. The interrupt flag is set by it only when the stop-interrupt enable is 1, so otherwise software polls the Stop flag.
- R4: Bits are taken on SCL rising edges, MSB first. An address byte whose upper seven bits equal `ownAddr` and whose bit 0 (R/W) is 0 is acknowledged by pulling SDA low for the ninth clock and is loaded into the buffer. Any other address byte is not acknowledged, and the bus is ignored until the next Start or Stop. The R/W flag takes bit 0 of every address byte.
- R5: A byte that completes while the buffer is full is answered with NACK, sets the overflow flag and leaves the buffer unchanged. With the overwrite enable at 1 the byte replaces the buffer content and is acknowledged. A set overflow flag also forces NACK. The overflow flag stays set until `ovfClr`.
- R6: The interrupt flag is set after the ninth falling SCL edge of every acknowledged byte and is not set there after a NACK. Only `irqClr` clears it. `bufRead` clears buffer-full.
- R7: With clock stretching enabled, SCL is held low after the acknowledge of each received byte and the clock-release bit is cleared. SCL is freed only once `relSet` sets the clock-release bit.
- R8: With address hold (or data hold) enabled, after the eighth falling SCL edge of an address (or data) byte the buffer already holds the byte. At that point the interrupt flag is set, the clock-release bit is cleared, the ack-timing flag is 1, and SCL is held low until `relSet`.
- R9: In hold mode the acknowledge bit is `ackDataIn` (0 = ACK, SDA low; 1 = NACK), sampled when the clock is released.
- R10: The ack-timing flag returns to 0 at the ninth falling SCL edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| sclOe | output | 1 | 1 pulls SCL low (stretch) |
| sdaOe | output | 1 | 1 pulls SDA low (ACK) |
| ownAddr | input | 7 | Own slave address |
| stretchEn | input | 1 | Stretch clock after each acknowledge |
| addrHoldEn | input | 1 | Hold before ACK of address bytes |
| dataHoldEn | input | 1 | Hold before ACK of data bytes |
| startIntEn | input | 1 | Interrupt on Start |
| stopIntEn | input | 1 | Interrupt on Stop |
| bufOvrEn | input | 1 | Allow overwrite of a full buffer |
| ackDataIn | input | 1 | Software ACK value in hold mode |
| bufRead | input | 1 | Pulse: software read of buffer |
| irqClr | input | 1 | Pulse: clear interrupt flag |
| ovfClr | input | 1 | Pulse: clear overflow flag |
| relSet | input | 1 | Pulse: set clock-release bit |
| rxData | output | 8 | Receive buffer |
| bufFull | output | 1 | Buffer holds unread byte |
| ovfFlag | output | 1 | Overflow flag |
| startSeen | output | 1 | Start detected last |
| stopSeen | output | 1 | Stop detected last |
| rwBit | output | 1 | R/W bit of last address byte |
| irqFlag | output | 1 | Interrupt flag |
| relBit | output | 1 | Clock-release bit |
| ackTim | output | 1 | Interrupt pending before ACK |

## Verification
Whole write transfers are replayed from a table of address and data pairs. The pairs cover a matching write, a different address, the own address with R/W set, an unread buffer, and the overwrite option, so that ACK, NACK, buffer retention and the R/W flag can be told apart. Directed transfers then show whether an interrupt comes from Start, Stop, a byte or a hold point. Further transfers keep SCL held with stretching or hold enabled until release, and show whether the software ACK value or the hardware decision reaches SDA on the ninth clock.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RECV, ST_HOLD, ST_ACK, ST_STRETCH, ST_SKIP
  } rxState_t;

  typedef struct packed {
    logic shiftEn;
    logic loadBuf;
    logic setOvf;
    logic setIrq;
    logic setStart;
    logic setStop;
    logic loadRw;
    logic clrRel;
    logic setAckTim;
    logic clrAckTim;
  } dpStrobe_t;
endpackage

// File: rtl/i2c_rx_dp.sv
module i2c_rx_dp
  import i2c_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              sdaBit,
  input  logic              bufRead,
  input  logic              irqClr,
  input  logic              ovfClr,
  input  logic              relSet,
  output logic [DATA_W-1:0] shiftReg,
  output logic [DATA_W-1:0] rxData,
  output logic              bufFull,
  output logic              ovfFlag,
  output logic              startSeen,
  output logic              stopSeen,
  output logic              rwBit,
  output logic              irqFlag,
  output logic              relBit,
  output logic              ackTim
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      rxData    <= '0;
      bufFull   <= 1'b0;
      ovfFlag   <= 1'b0;
      startSeen <= 1'b0;
      stopSeen  <= 1'b0;
      rwBit     <= 1'b0;
      irqFlag   <= 1'b0;
      relBit    <= 1'b1;
      ackTim    <= 1'b0;
    end else begin
      if (strobe.shiftEn) shiftReg <= {shiftReg[DATA_W-2:0], sdaBit};
      if (strobe.loadBuf) rxData <= shiftReg;

      if (strobe.loadBuf)  bufFull <= 1'b1;
      else if (bufRead)    bufFull <= 1'b0;

      if (strobe.setOvf)   ovfFlag <= 1'b1;
      else if (ovfClr)     ovfFlag <= 1'b0;

      if (strobe.setIrq)   irqFlag <= 1'b1;
      else if (irqClr)     irqFlag <= 1'b0;

      if (strobe.setStart) begin
        startSeen <= 1'b1;
        stopSeen  <= 1'b0;
      end else if (strobe.setStop) begin
        stopSeen  <= 1'b1;
        startSeen <= 1'b0;
      end

      if (strobe.loadRw) rwBit <= shiftReg[0];

      if (strobe.clrRel)  relBit <= 1'b0;
      else if (relSet)    relBit <= 1'b1;

      if (strobe.setAckTim)      ackTim <= 1'b1;
      else if (strobe.clrAckTim) ackTim <= 1'b0;
    end
  end

  // R5: an overflowing byte never lands in the buffer
  assert_ovf_keeps_buf_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> $stable(rxData));

  // R6: the interrupt flag is sticky until software clears it
  assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !irqClr) |=> irqFlag);

endmodule

// File: rtl/i2c_rx_ctrl.sv
module i2c_rx_ctrl
  import i2c_rx_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic [DATA_W-1:0] shiftReg,
  input  logic              bufFull,
  input  logic              ovfFlag,
  input  logic              relBit,
  input  logic              ackTim,
  input  logic              ackDataIn,
  input  logic              stretchEn,
  input  logic              addrHoldEn,
  input  logic              dataHoldEn,
  input  logic              startIntEn,
  input  logic              stopIntEn,
  input  logic              bufOvrEn,
  output dpStrobe_t         strobe,
  output logic              sdaBit,
  output logic              sclOe,
  output logic              sdaOe
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclPrev, sdaPrev;
  logic sclRise, sclFall, startEv, stopEv;

  rxState_t         state, stateNxt;
  logic [CNT_W-1:0] bitCnt, cntNxt;
  logic             isAddr, isAddrNxt, nack, nackNxt;
  logic             addrMatch, blockFull, holdThis, byteDone;

  // line synchronizers, depth chosen by parameter
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= sclIn;
          sdaPipe <= sdaIn;
        end
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
          sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
        end
      end
    end
  endgenerate

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];
  assign sdaBit = sdaS;

  assign sclRise = sclS && !sclPrev;
  assign sclFall = !sclS && sclPrev;
  assign startEv = sclS && sclPrev && sdaPrev && !sdaS;
  assign stopEv  = sclS && sclPrev && !sdaPrev && sdaS;

  assign addrMatch = (shiftReg[DATA_W-1 -: ADDR_W] == ownAddr) && !shiftReg[0];
  assign blockFull = bufFull && !bufOvrEn;
  assign holdThis  = isAddr ? addrHoldEn : dataHoldEn;
  assign byteDone  = sclFall && (bitCnt == LAST_BIT);

  always_comb begin
    stateNxt  = state;
    cntNxt    = bitCnt;
    isAddrNxt = isAddr;
    nackNxt   = nack;
    strobe    = '0;
    if (startEv) begin
      strobe.setStart = 1'b1;
      strobe.setIrq   = startIntEn;
      strobe.clrAckTim = 1'b1;
      stateNxt  = ST_RECV;
      cntNxt    = '0;
      isAddrNxt = 1'b1;
    end else if (stopEv) begin
      strobe.setStop = 1'b1;
      strobe.setIrq  = stopIntEn;
      strobe.clrAckTim = 1'b1;
      stateNxt = ST_IDLE;
    end else begin
      unique case (state)
        ST_RECV: begin
          if (sclRise && bitCnt < LAST_BIT) begin
            strobe.shiftEn = 1'b1;
            cntNxt = bitCnt + 1'b1;
          end
          if (byteDone) begin
            strobe.loadRw = isAddr;
            if (isAddr && !addrMatch) begin
              stateNxt = ST_SKIP;
            end else begin
              strobe.loadBuf = !blockFull;
              strobe.setOvf  = blockFull;
              nackNxt = blockFull || ovfFlag;
              if (holdThis) begin
                strobe.setIrq    = 1'b1;
                strobe.clrRel    = 1'b1;
                strobe.setAckTim = 1'b1;
                stateNxt = ST_HOLD;
              end else begin
                stateNxt = ST_ACK;
              end
            end
          end
        end
        ST_HOLD: begin
          if (relBit) begin
            nackNxt  = ackDataIn;
            stateNxt = ST_ACK;
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            strobe.clrAckTim = 1'b1;
            cntNxt    = '0;
            isAddrNxt = 1'b0;
            if (nack) begin
              stateNxt = ST_SKIP;
            end else begin
              strobe.setIrq = 1'b1;
              if (stretchEn) begin
                strobe.clrRel = 1'b1;
                stateNxt = ST_STRETCH;
              end else begin
                stateNxt = ST_RECV;
              end
            end
          end
        end
        ST_STRETCH: if (relBit) stateNxt = ST_RECV;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
      state   <= ST_IDLE;
      bitCnt  <= '0;
      isAddr  <= 1'b0;
      nack    <= 1'b0;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
      state   <= stateNxt;
      bitCnt  <= cntNxt;
      isAddr  <= isAddrNxt;
      nack    <= nackNxt;
    end
  end

  assign sdaOe = (state == ST_ACK) && !nack;
  assign sclOe = (state == ST_HOLD) || (state == ST_STRETCH);

  // R7: whenever the clock starts being held, the release bit reads 0
  assert_rel_cleared_on_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclOe) |-> !relBit);

  // R8: while waiting in hold the timing flag marks a pre-ACK interrupt
  assert_acktim_in_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD) |-> ackTim);

  // R4: the ACK drive is let go only while SCL is low
  assert_sda_release_scl_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaOe) |-> !sclS);

  // R10: the timing flag drops only when leaving the ACK clock or on a bus condition
  assert_acktim_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ackTim) |-> ($past(state) == ST_ACK || $past(startEv) || $past(stopEv)));

endmodule

// File: rtl/i2c_hold_rx.sv
module i2c_hold_rx
  import i2c_rx_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclOe,
  output logic              sdaOe,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              stretchEn,
  input  logic              addrHoldEn,
  input  logic              dataHoldEn,
  input  logic              startIntEn,
  input  logic              stopIntEn,
  input  logic              bufOvrEn,
  input  logic              ackDataIn,
  input  logic              bufRead,
  input  logic              irqClr,
  input  logic              ovfClr,
  input  logic              relSet,
  output logic [DATA_W-1:0] rxData,
  output logic              bufFull,
  output logic              ovfFlag,
  output logic              startSeen,
  output logic              stopSeen,
  output logic              rwBit,
  output logic              irqFlag,
  output logic              relBit,
  output logic              ackTim
);

  dpStrobe_t         strobe;
  logic              sdaBit;
  logic [DATA_W-1:0] shiftReg;

  i2c_rx_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .ownAddr(ownAddr),
    .shiftReg(shiftReg), .bufFull(bufFull), .ovfFlag(ovfFlag), .relBit(relBit),
    .ackTim(ackTim), .ackDataIn(ackDataIn), .stretchEn(stretchEn),
    .addrHoldEn(addrHoldEn), .dataHoldEn(dataHoldEn), .startIntEn(startIntEn),
    .stopIntEn(stopIntEn), .bufOvrEn(bufOvrEn), .strobe(strobe), .sdaBit(sdaBit),
    .sclOe(sclOe), .sdaOe(sdaOe)
  );

  i2c_rx_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdaBit(sdaBit), .bufRead(bufRead),
    .irqClr(irqClr), .ovfClr(ovfClr), .relSet(relSet), .shiftReg(shiftReg),
    .rxData(rxData), .bufFull(bufFull), .ovfFlag(ovfFlag), .startSeen(startSeen),
    .stopSeen(stopSeen), .rwBit(rwBit), .irqFlag(irqFlag), .relBit(relBit),
    .ackTim(ackTim)
  );

endmodule

// File: tb/i2c_hold_rx_tb_top.sv
module i2c_hold_rx_tb_top;
  localparam int H = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic sclOe, sdaOe, sclLine, sdaLine;
  logic stretchEn = 0, addrHoldEn = 0, dataHoldEn = 0, startIntEn = 0, stopIntEn = 0;
  logic bufOvrEn = 0, ackDataIn = 0, bufRead = 0, irqClr = 0, ovfClr = 0, relSet = 0;
  logic [7:0] rxData;
  logic bufFull, ovfFlag, startSeen, stopSeen, rwBit, irqFlag, relBit, ackTim;
  int nRun = 0, nFail = 0;
  bit ack;

  always #5 clk = ~clk;
  assign sclLine = mScl & ~sclOe;
  assign sdaLine = mSda & ~sdaOe;

  i2c_hold_rx dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine), .sclOe(sclOe), .sdaOe(sdaOe),
    .ownAddr(7'h5A), .stretchEn(stretchEn), .addrHoldEn(addrHoldEn), .dataHoldEn(dataHoldEn),
    .startIntEn(startIntEn), .stopIntEn(stopIntEn), .bufOvrEn(bufOvrEn), .ackDataIn(ackDataIn),
    .bufRead(bufRead), .irqClr(irqClr), .ovfClr(ovfClr), .relSet(relSet), .rxData(rxData),
    .bufFull(bufFull), .ovfFlag(ovfFlag), .startSeen(startSeen), .stopSeen(stopSeen),
    .rwBit(rwBit), .irqFlag(irqFlag), .relBit(relBit), .ackTim(ackTim)
  );

  // addr, data, readAfterAddr, overwriteEn, expAddrAck, expDataAck, expBuf, expOvf, expRw
  localparam logic [29:0] VEC [0:6] = '{
    {8'hB4, 8'h3C, 1'b1, 1'b0, 1'b1, 1'b1, 8'h3C, 1'b0, 1'b0},
    {8'hB4, 8'h77, 1'b0, 1'b0, 1'b1, 1'b0, 8'hB4, 1'b1, 1'b0},
    {8'hB4, 8'h81, 1'b0, 1'b1, 1'b1, 1'b1, 8'h81, 1'b0, 1'b0},
    {8'hB6, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h81, 1'b0, 1'b0},
    {8'hB5, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h81, 1'b0, 1'b1},
    {8'hB4, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b1, 8'hFF, 1'b0, 1'b0},
    {8'hB4, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cmp(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
    waitCyc(4);
  endtask

  task automatic startCond;
    mSda = 1'b1; mScl = 1'b1; waitCyc(H);
    mSda = 1'b0; waitCyc(H);
    mScl = 1'b0; waitCyc(H);
  endtask

  task automatic stopCond;
    mSda = 1'b0; waitCyc(H);
    mScl = 1'b1; while (!sclLine) @(negedge clk);
    waitCyc(H);
    mSda = 1'b1; waitCyc(H);
  endtask

  task automatic sendBits(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; waitCyc(H);
      mScl = 1'b1; while (!sclLine) @(negedge clk);
      waitCyc(H);
      mScl = 1'b0; waitCyc(H);
    end
    mSda = 1'b1;
  endtask

  task automatic ackBit(output bit a);
    mSda = 1'b1; waitCyc(H);
    mScl = 1'b1; while (!sclLine) @(negedge clk);
    waitCyc(H / 2);
    a = !sdaLine;
    waitCyc(H / 2);
    mScl = 1'b0; waitCyc(H);
  endtask

  task automatic writeByte(input logic [7:0] b, output bit a);
    sendBits(b);
    ackBit(a);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    waitCyc(10);
    // R1: reset values
    cmp("R1 bufFull", bufFull, 0);
    cmp("R1 ovfFlag", ovfFlag, 0);
    cmp("R1 irqFlag", irqFlag, 0);
    cmp("R1 relBit", relBit, 1);
    cmp("R1 ackTim", ackTim, 0);
    cmp("R1 start/stop", {startSeen, stopSeen}, 0);
    cmp("R1 line drive", {sclOe, sdaOe}, 0);
    @(negedge clk); rstN = 1'b1;
    waitCyc(5);

    // table of whole write transfers (R4, R5)
    for (int i = 0; i < 7; i++) begin
      logic [29:0] v;
      bit aAck, dAck;
      v = VEC[i];
      pulse(bufRead);
      pulse(ovfClr);
      bufOvrEn = v[12];
      startCond();
      writeByte(v[29:22], aAck);
      if (v[13]) pulse(bufRead);
      writeByte(v[21:14], dAck);
      stopCond();
      cmp($sformatf("R4 addr ack vec%0d", i), aAck, v[11]);
      cmp($sformatf("R5 data ack vec%0d", i), dAck, v[10]);
      cmp($sformatf("R5 buffer vec%0d", i), rxData, v[9:2]);
      cmp($sformatf("R5 overflow vec%0d", i), ovfFlag, v[1]);
      cmp($sformatf("R4 rw flag vec%0d", i), rwBit, v[0]);
    end
    bufOvrEn = 0;
    pulse(bufRead);
    cmp("R6 bufRead clears full", bufFull, 0);

    // R2 / R3: start and stop flags with and without interrupts
    pulse(irqClr);
    startIntEn = 1;
    startCond();
    cmp("R2 start flag", {startSeen, stopSeen}, 2'b10);
    cmp("R2 start irq enabled", irqFlag, 1);
    pulse(irqClr);
    stopCond();
    cmp("R3 stop flag polled", {startSeen, stopSeen}, 2'b01);
    cmp("R3 no stop irq when disabled", irqFlag, 0);
    startIntEn = 0;
    startCond();
    cmp("R2 no start irq when disabled", irqFlag, 0);
    stopIntEn = 1;
    stopCond();
    cmp("R3 stop irq enabled", irqFlag, 1);
    stopIntEn = 0;
    pulse(irqClr);

    // R6: interrupt per acknowledged byte, none after NACK
    startCond();
    writeByte(8'hB4, ack);
    cmp("R6 irq after addr ack", irqFlag, 1);
    pulse(irqClr);
    cmp("R6 irq cleared by software", irqFlag, 0);
    pulse(bufRead);
    writeByte(8'h55, ack);
    cmp("R6 irq after data ack", irqFlag, 1);
    stopCond();
    pulse(bufRead);
    pulse(irqClr);
    startCond();
    writeByte(8'hB6, ack);
    cmp("R6 no irq after nack", irqFlag, 0);
    stopCond();

    // R7: clock stretching after each acknowledge
    stretchEn = 1;
    startCond();
    writeByte(8'hB4, ack);
    cmp("R7 scl held after ack", sclOe, 1);
    cmp("R7 release bit cleared", relBit, 0);
    waitCyc(30);
    cmp("R7 still held", sclOe, 1);
    pulse(relSet);
    cmp("R7 scl freed on relSet", {sclOe, relBit}, 2'b01);
    pulse(bufRead);
    writeByte(8'h12, ack);
    cmp("R7 data ack under stretch", ack, 1);
    cmp("R7 held after data", sclOe, 1);
    pulse(relSet);
    stopCond();
    stretchEn = 0;
    pulse(bufRead);
    pulse(irqClr);

    // R8 / R9 / R10: address hold with software NACK
    addrHoldEn = 1;
    startCond();
    sendBits(8'hB4);
    cmp("R8 hold irq before ack", irqFlag, 1);
    cmp("R8 acktim set", ackTim, 1);
    cmp("R8 release bit cleared", relBit, 0);
    cmp("R8 scl held", sclOe, 1);
    cmp("R8 address in buffer", rxData, 8'hB4);
    pulse(irqClr);
    ackDataIn = 1;
    pulse(relSet);
    ackBit(ack);
    cmp("R9 software nack sent", ack, 0);
    cmp("R9 no irq after nack", irqFlag, 0);
    cmp("R10 acktim cleared", ackTim, 0);
    stopCond();
    addrHoldEn = 0;
    ackDataIn = 0;
    pulse(bufRead);

    // R8 / R9 / R10: data hold with software ACK
    dataHoldEn = 1;
    startCond();
    writeByte(8'hB4, ack);
    cmp("R4 addr ack before data hold", ack, 1);
    pulse(bufRead);
    pulse(irqClr);
    sendBits(8'hA5);
    cmp("R8 data hold irq", irqFlag, 1);
    cmp("R8 data acktim", ackTim, 1);
    cmp("R8 data scl held", sclOe, 1);
    cmp("R8 data in buffer", rxData, 8'hA5);
    pulse(irqClr);
    pulse(relSet);
    ackBit(ack);
    cmp("R9 software ack sent", ack, 1);
    cmp("R6 irq after held ack", irqFlag, 1);
    cmp("R10 data acktim cleared", ackTim, 0);
    stopCond();
    dataHoldEn = 0;

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule